// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block merges every reset source of a small battery-powered controller into one synchronous core reset. Power-up comes in as an asynchronous active-low event. The low-voltage-reset comparator and the low-battery comparator arrive as digital levels. The watchdog is restarted through a strobe that fires on each write to the interrupt-control register, together with the 4-bit value written.

Any reset source, or a watchdog that runs out, starts a hold counter. The core stays in reset until that counter has spanned a fixed delay. While the core is in reset, the watchdog counter is held at zero. When the reset ends, the watchdog counts up once per cycle. It restarts only when the write carries the clear key 0xE. The low-battery comparator is brought out as a read-only flag and never causes a reset. Both durations are parameters in clock cycles: the default hold is 16 ms and the default watchdog period is 0.45 s, both at a 1 MHz clock.

Top module: `rst_supervisor`

## Requirements
- R1: `core_rst` is 1 while `por_n` is 0, and falls on the HOLD_CYC-th rising edge after `por_n` returns to 1.
- R2: `lvr_low` passes through two synchroniser flops. Once it reaches the hold logic, `core_rst` rises on the next edge and stays 1 while the level stays high. It falls HOLD_CYC edges after the synchronised level drops.
- R3: `batt_ok` equals `lvd_ok` delayed by two rising edges. It reads 0 after power-on and does not depend on `core_rst`.
- R4: Without a clear, `core_rst` rises on the WDT_CYC-th rising edge after it fell.
- R5: A write (`reg_wr`=1) with `reg_wdata`=4'hE restarts the count. `core_rst` then rises on the WDT_CYC-th edge after the edge that took the write.
- R6: A write with any value other than 4'hE has no effect on when the watchdog fires.
- R7: A watchdog timeout holds `core_rst` at 1 for HOLD_CYC edges, and the watchdog count is zero while reset is held.
- R8: A clear write that lands in the last cycle before expiry wins, and no reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on event, asynchronous, active low |
| lvr_low | input | 1 | Supply below reset point (asynchronous level) |
| lvd_ok | input | 1 | Supply above detect threshold (asynchronous level) |
| reg_wr | input | 1 | Write strobe of the interrupt-control register |
| reg_wdata | input | 4 | Value written to that register |
| core_rst | output | 1 | Synchronous core reset, active high |
| batt_ok | output | 1 | Read-only low-battery flag, 0 = low |

## Verification
A watchdog restart and a watchdog expiry can fall in the same cycle. The bench sweeps the clear write across every cycle of the watchdog window, up to and including the final cycle where the count sits at its limit. For each position it measures how long the reset stays released and compares that length with the offset plus WDT_CYC. A mistaken priority would show up as a reset at the old expiry time.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  localparam logic [3:0] WDT_KEY = 4'hE;

  function automatic logic key_match(input logic wr, input logic [3:0] data);
    return wr && (data == WDT_KEY);
  endfunction

  function automatic logic at_last(input int unsigned cnt, input int unsigned span);
    return cnt == span - 1;
  endfunction
endpackage

// File: rtl/rsup_sync2.sv
module rsup_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rsup_hold.sv
module rsup_hold #(
  parameter int HOLD_CYC = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic hold_rst
);
  import rsup_pkg::*;
  localparam int HW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  logic [HW-1:0] hold_cnt;
  logic          hold_done;

  assign hold_done = at_last(int'(hold_cnt), HOLD_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_rst <= 1'b1;
      hold_cnt <= '0;
    end else if (trigger) begin
      hold_rst <= 1'b1;
      hold_cnt <= '0;
    end else if (hold_rst) begin
      if (hold_done) hold_rst <= 1'b0;
      else           hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R1: release only after the full hold count
  p_release_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_rst) |-> $past(hold_cnt) == HW'(HOLD_CYC - 1));

  // R2, R7: any trigger puts the core into reset on the next edge
  p_trigger_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> hold_rst);
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int WDT_CYC = 450000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_rst,
  input  logic       reg_wr,
  input  logic [3:0] reg_wdata,
  output logic       wdt_fire
);
  import rsup_pkg::*;
  localparam int WW = $clog2(WDT_CYC);

  logic [WW-1:0] wdt_cnt;
  logic          clr_hit;
  logic          at_limit;

  assign clr_hit  = key_match(reg_wr, reg_wdata);
  assign at_limit = at_last(int'(wdt_cnt), WDT_CYC);
  assign wdt_fire = at_limit && !clr_hit && !core_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wdt_cnt <= '0;
    else if (core_rst || clr_hit) wdt_cnt <= '0;
    else if (!at_limit)           wdt_cnt <= wdt_cnt + 1'b1;
  end

  // R7: the count is zero in the cycle after any reset cycle
  p_zero_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> wdt_cnt == '0);

  // R6: a write without the key does not disturb the count
  p_other_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata != WDT_KEY && !core_rst && !at_limit)
      |=> wdt_cnt == $past(wdt_cnt) + 1'b1);

  // R8: a clear write in the final cycle suppresses the timeout
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && at_limit) |-> !wdt_fire);

  // R5: a key write restarts the count
  p_key_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !core_rst) |=> wdt_cnt == '0);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_CYC = 16000,
  parameter int WDT_CYC  = 450000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lvr_low,
  input  logic       lvd_ok,
  input  logic       reg_wr,
  input  logic [3:0] reg_wdata,
  output logic       core_rst,
  output logic       batt_ok
);
  logic [1:0] sync_q;
  logic       lvr_s;
  logic       wdt_fire;
  logic       rst_trigger;

  rsup_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({lvd_ok, lvr_low}),
    .q     (sync_q)
  );

  assign lvr_s       = sync_q[0];
  assign batt_ok     = sync_q[1];
  assign rst_trigger = lvr_s || wdt_fire;

  rsup_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst_n    (por_n),
    .trigger  (rst_trigger),
    .hold_rst (core_rst)
  );

  rsup_wdog #(.WDT_CYC(WDT_CYC)) u_wdog (
    .clk       (clk),
    .rst_n     (por_n),
    .core_rst  (core_rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .wdt_fire  (wdt_fire)
  );

  // R4: a timeout leads to reset on the next edge
  p_timeout_resets_r4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_fire |=> core_rst);

  // R2: a held synchronised low-voltage level keeps reset asserted
  p_lvr_holds_r2: assert property (@(posedge clk) disable iff (!por_n)
    (lvr_s && $past(lvr_s)) |-> core_rst);
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int HOLD = 5;
  localparam int WDT  = 12;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       lvr_low = 1'b0;
  logic       lvd_ok = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic       core_rst;
  logic       batt_ok;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rst_supervisor #(.HOLD_CYC(HOLD), .WDT_CYC(WDT)) u_rst_supervisor (
    .clk(clk), .por_n(por_n), .lvr_low(lvr_low), .lvd_ok(lvd_ok),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .core_rst(core_rst), .batt_ok(batt_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starting at a negedge with core_rst high, count later negedges still high.
  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!core_rst) break;
      n++;
    end
  endtask

  // Starting at the first negedge with core_rst low, optionally write at step k.
  task automatic count_low(input int k, input logic [3:0] d, input bit wr, output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      reg_wr    = wr && (i == k);
      reg_wdata = d;
      @(negedge clk);
      if (core_rst) break;
      n++;
    end
    reg_wr = 1'b0;
  endtask

  initial begin
    int n;
    // reset state (R1, R3)
    repeat (3) @(negedge clk);
    check("R1 reset state core_rst", int'(core_rst), 1);
    check("R3 reset state batt_ok", int'(batt_ok), 0);

    // R1: power-on hold length
    por_n = 1'b1;
    count_high(n);
    check("R1 power-on hold", n, HOLD - 1);

    // R4: plain timeout, then R7: hold after timeout
    count_low(0, 4'h0, 1'b0, n);
    check("R4 timeout window", n, WDT - 1);
    count_high(n);
    check("R7 timeout hold", n, HOLD - 1);

    // R5, R8: key write at every offset of the window
    for (int k = 0; k < WDT; k++) begin
      count_low(k, 4'hE, 1'b1, n);
      check((k == WDT - 1) ? "R8 clear at expiry" : "R5 clear restart", n, k + WDT);
      count_high(n);
      check("R7 hold after restart run", n, HOLD - 1);
    end

    // R6: every other value, written mid-window
    for (int v = 0; v < 16; v++) begin
      if (v == 14) continue;
      count_low(WDT / 2, 4'(v), 1'b1, n);
      check("R6 non-key write ignored", n, WDT - 1);
      count_high(n);
    end
    // R6: non-key at final cycle still times out
    count_low(WDT - 1, 4'h5, 1'b1, n);
    check("R6 non-key at expiry", n, WDT - 1);
    count_high(n);

    // R2: low-voltage reset
    lvr_low = 1'b1;
    count_low(0, 4'h0, 1'b0, n);
    check("R2 sync delay to reset", n, 2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R2 held during low voltage", int'(core_rst), 1);
    end
    lvr_low = 1'b0;
    count_high(n);
    check("R2 release after drop", n, HOLD + 1);

    // R3: flag follows comparator, also during reset
    lvd_ok = 1'b1;
    @(negedge clk);
    check("R3 flag after one edge", int'(batt_ok), 0);
    @(negedge clk);
    check("R3 flag after two edges", int'(batt_ok), 1);
    check("R3 no reset from flag", int'(core_rst), 0);
    lvr_low = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 flag during reset", int'(batt_ok), 1);
    lvd_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 flag drops", int'(batt_ok), 0);
    check("R3 reset still held", int'(core_rst), 1);
    lvr_low = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule